// File: doc/BRIEF.md
# Oscillator Drift Trim Prescaler

This block divides a 32768 Hz oscillator clock into a one-second tick and corrects the oscillator's frequency error by stretching or shrinking one chosen second. A trim word sets the correction. It holds a window bit, which selects a correction once every 60 seconds or once every 20 seconds. It holds a direction bit, which selects adding or removing pulses. It also holds a 6-bit amount. Each step is two oscillator pulses, so one corrected second can gain or lose between 2 and 124 pulses. With the 60 s window one step is about 1017 ppb. With the 20 s window one step is about 3051 ppb. The total range reaches about 190 ppm.

Software writes a trim word through a single-cycle write strobe. The word is held as pending, and a busy flag is raised. At the next one-second boundary the word becomes active and the busy flag drops. The block counts its own seconds inside the correction window. Only the first second of each window is corrected. The window count restarts whenever a new word becomes active.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no active correction every second lasts exactly CYC_PER_SEC cycles, and `tick_1hz` is high for exactly one cycle, the last cycle of each second.
- R2: With direction bit `wr_word[6]`=0 and amount `wr_word[5:0]`=F in 2..63, the first second of each window lasts CYC_PER_SEC + 2·(F−1) cycles.
- R3: With `wr_word[6]`=1 and F in 2..63, the first second of each window lasts CYC_PER_SEC − 2·(64−F) cycles. This is the one's-complement encoding of steps−1.
- R4: Amount 0 in either direction, amount 1 with the direction bit clear, and amount 1 with the direction bit set each give no correction: every second is nominal.
- R5: Window bit `wr_word[7]`=1 gives a 60-second window and `wr_word[7]`=0 gives a 20-second window. Only second 0 of each window is corrected, and seconds 1..N−1 are nominal.
- R6: A written word takes effect at the first one-second boundary after the write. The window count restarts there, so the very next second is a corrected second. The active word never changes in the middle of a second.
- R7: `busy` goes high the cycle after an accepted write. It stays high through the end of the current second and is low in the first cycle of the next second.
- R8: A write made while `busy` is high is ignored. The earlier pending word takes effect unchanged.
- R9: A synchronous reset clears the prescaler, the window counter and the active word to zero, and clears `busy`. The first tick after reset is released comes CYC_PER_SEC cycles later, counting the release cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the trim word |
| wr_word | input | 8 | Trim word: [7] 60 s window, [6] remove pulses, [5:0] amount |
| busy | output | 1 | A written word is pending and waiting for the next boundary |
| tick_1hz | output | 1 | One-cycle pulse on the last cycle of each second |

## Verification
The hardest condition to reach is the repeat of the correction at the end of a full 60-second window. At the real oscillator rate that takes about two million cycles. The bench therefore shrinks the second to 256 cycles while keeping the 20 and 60 second windows. It then measures every second across a whole window plus one, so the corrected second is seen both at the restart and again when the window wraps. The ignored-write case is reached by issuing a second write one cycle after the first, while the flag is still raised.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int AMT_W     = 6;
    localparam int MAX_STEPS = (1 << AMT_W) - 2;

    // Trim word layout: [7] long window, [6] remove pulses, [5:0] amount
    typedef struct packed {
        logic             long_win;
        logic             remove;
        logic [AMT_W-1:0] amount;
    } trim_word_t;

    localparam int WORD_W = $bits(trim_word_t);

    // Step count carried by a trim word; amounts below 2 mean no trim
    function automatic logic [AMT_W-1:0] trim_steps(trim_word_t w);
        logic [AMT_W-1:0] s;
        if (w.amount < AMT_W'(2))
            s = '0;
        else if (w.remove)
            s = ~w.amount + AMT_W'(1);
        else
            s = w.amount - AMT_W'(1);
        return s;
    endfunction

endpackage

// File: rtl/trim_prescaler_ctr.sv
module trim_prescaler_ctr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] sec_len,
    output logic             tick
);

    logic [LEN_W-1:0] cnt;

    assign tick = (cnt == sec_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + LEN_W'(1);
    end

    assert_cnt_below_len_R1: assert property (@(posedge clk) disable iff (rst)
        cnt < sec_len);

    assert_wrap_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/trim_interval_ctr.sv
module trim_interval_ctr #(
    parameter int SHORT_SECS = 20,
    parameter int LONG_SECS  = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic long_win,
    output logic first_sec
);

    localparam int IW = $clog2(LONG_SECS);

    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;

    assign last_idx  = long_win ? IW'(LONG_SECS - 1) : IW'(SHORT_SECS - 1);
    assign first_sec = (idx == '0);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (tick) begin
            if (restart || idx == last_idx)
                idx <= '0;
            else
                idx <= idx + IW'(1);
        end
    end

    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && restart) |=> (idx == '0));

    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(idx));

    assert_idx_in_window_R5: assert property (@(posedge clk) disable iff (rst)
        idx <= last_idx);

endmodule

// File: rtl/trim_word_latch.sv
module trim_word_latch
    import rtc_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  trim_word_t wr_word,
    input  logic       tick,
    output trim_word_t active,
    output logic       busy,
    output logic       apply
);

    trim_word_t pend;
    logic       pend_vld;

    assign busy  = pend_vld;
    assign apply = tick && pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            pend_vld <= 1'b0;
            active   <= '0;
        end else if (apply) begin
            active   <= pend;
            pend_vld <= 1'b0;
        end else if (wr_en && !pend_vld) begin
            pend     <= wr_word;
            pend_vld <= 1'b1;
        end
    end

    assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

    assert_busy_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && tick) |=> !busy);

    assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(pend));

    assert_active_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(active));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int CYC_PER_SEC = 32768,
    parameter int SHORT_SECS  = 20,
    parameter int LONG_SECS   = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic              busy,
    output logic              tick_1hz
);

    localparam int LEN_W = $clog2(CYC_PER_SEC + 2 * MAX_STEPS + 1);

    trim_word_t       w_in;
    trim_word_t       active;
    logic             apply;
    logic             first_sec;
    logic [AMT_W-1:0] steps;
    logic [LEN_W-1:0] delta;
    logic [LEN_W-1:0] sec_len;

    assign w_in  = trim_word_t'(wr_word);
    assign steps = trim_steps(active);
    assign delta = LEN_W'({steps, 1'b0});

    always_comb begin
        if (first_sec && steps != '0)
            sec_len = active.remove ? LEN_W'(CYC_PER_SEC) - delta
                                    : LEN_W'(CYC_PER_SEC) + delta;
        else
            sec_len = LEN_W'(CYC_PER_SEC);
    end

    trim_word_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (w_in),
        .tick    (tick_1hz),
        .active  (active),
        .busy    (busy),
        .apply   (apply)
    );

    trim_interval_ctr #(
        .SHORT_SECS (SHORT_SECS),
        .LONG_SECS  (LONG_SECS)
    ) u_interval (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1hz),
        .restart   (apply),
        .long_win  (active.long_win),
        .first_sec (first_sec)
    );

    trim_prescaler_ctr #(
        .LEN_W (LEN_W)
    ) u_prescale (
        .clk     (clk),
        .rst     (rst),
        .sec_len (sec_len),
        .tick    (tick_1hz)
    );

    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |=> !tick_1hz);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!busy && !tick_1hz));

endmodule

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 256;
    localparam int SHORT_N    = 20;
    localparam int LONG_N     = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_word = '0;
    logic       busy;
    logic       tick_1hz;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_trim_prescaler #(
        .CYC_PER_SEC (CYC),
        .SHORT_SECS  (SHORT_N),
        .LONG_SECS   (LONG_N)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .busy     (busy),
        .tick_1hz (tick_1hz)
    );

    function automatic int exp_len(logic [7:0] w, int idx);
        int f;
        int st;
        f = int'(w[5:0]);
        if (f < 2) st = 0;
        else if (w[6]) st = 64 - f;
        else st = f - 1;
        if (idx != 0) return CYC;
        return w[6] ? CYC - 2 * st : CYC + 2 * st;
    endfunction

    function automatic string tag_of(logic [7:0] w);
        if (w[5:0] < 6'd2) return "R4";
        return w[6] ? "R3" : "R2";
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_tick();
        while (1) begin
            @(negedge clk);
            if (tick_1hz) break;
        end
    endtask

    task automatic measure(output int n, output logic b0);
        n = 0;
        b0 = 1'b0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) b0 = busy;
            if (tick_1hz) break;
        end
    endtask

    // Write w; optionally try a second write w2 while busy (must be ignored)
    task automatic run_case(logic [7:0] w, bit second, logic [7:0] w2);
        int   p;
        logic b0;
        int   nwin;
        wait_tick();
        @(negedge clk);
        wr_en = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
        check(busy == 1'b1, "R7", busy, 1);
        if (second) begin
            wr_en = 1'b1;
            wr_word = w2;
            @(negedge clk);
            wr_en = 1'b0;
        end
        wait_tick();
        check(busy == 1'b1, "R7", busy, 1);
        nwin = w[7] ? LONG_N : SHORT_N;
        for (int s = 0; s <= nwin; s++) begin
            measure(p, b0);
            if (s == 0) check(b0 == 1'b0, "R7", b0, 0);
            if (s == 0 || s == nwin)
                check(p == exp_len(w, s % nwin), second ? "R8" : tag_of(w), p, exp_len(w, s % nwin));
            else
                check(p == CYC, "R5", p, CYC);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 19000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int   p;
        logic b0;
        int   seed_sink;
        logic [7:0] w;
        seed_sink = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        check(tick_1hz == 1'b0, "R9", tick_1hz, 0);
        check(busy == 1'b0, "R9", busy, 0);
        rst = 1'b0;
        measure(p, b0);
        check(p + 1 == CYC, "R9", p + 1, CYC);
        measure(p, b0);
        check(p == CYC, "R1", p, CYC);

        run_case(8'b1_0_111111, 1'b0, 8'h00);   // R2 max add, long window
        run_case(8'b0_1_000010, 1'b0, 8'h00);   // R3 max remove, short window
        run_case(8'b0_0_000001, 1'b0, 8'h00);   // R4 amount 1 add
        run_case(8'b0_1_000001, 1'b0, 8'h00);   // R4 amount 1 remove
        run_case(8'b1_1_000000, 1'b0, 8'h00);   // R4 amount 0 remove, R5 long
        run_case(8'b0_0_000000, 1'b0, 8'h00);   // R4 amount 0
        run_case(8'b0_0_001010, 1'b1, 8'b1_1_010100); // R8 ignored write, R6
        for (int k = 0; k < 6; k++) begin
            w = 8'($urandom);
            run_case(w, 1'b0, 8'h00);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule